// File: doc/BRIEF.md
# Peripheral Busy/Done Flag Controller

This block is the per-device status logic for one channel on a shared processor I/O backplane. The processor broadcasts commands carrying a channel number and an operation code. The block reacts only to commands that carry its own channel number. It keeps a busy flag and a done flag that together describe the device's operation. A start command begins an operation. A completion pulse from the device datapath ends it: busy falls and done rises on the same clock edge.

The done flag sources the device's interrupt request. The request is gated by a global interrupt enable input and by a local mask bit, which a dedicated command loads. A clear command drops both flags and so withdraws the request. Two skip-test commands give the processor a combinational skip response in the command cycle: one tests done for zero, the other tests done for one.

Top module: `io_flag_ctrl`

## Requirements
- R1: After reset, busy, done, the mask bit, irq and skip are all 0.
- R2: A start command (op code 1) that matches the channel sets busy to 1 and done to 0 on the next clock edge, whatever done was before.
- R3: A pulse on `op_complete` while busy is 1, with no matching start or clear in the same cycle, clears busy and sets done on the same edge.
- R4: A pulse on `op_complete` while busy is 0 changes neither flag.
- R5: `irq` is 1 exactly when done is 1, `int_enable` is 1 and the mask bit is 0.
- R6: A clear command (op code 2) that matches the channel sets busy and done to 0 on the next edge, so irq drops.
- R7: `skip` is combinational in the command cycle. It is 1 for a matching op code 3 when done is 0, and for a matching op code 4 when done is 1. It is 0 in every other case.
- R8: A command with `cmd_valid` low, or with a channel number other than the parameter `CHANNEL` (6 bits wide by default), changes no flag, mask or skip.
- R9: A matching mask-write command (op code 5) loads the mask bit from `cmd_arg` on the next edge. Op codes 0, 6 and 7 have no effect.
- R10: When a matching start or clear arrives in the same cycle as a completion pulse, the command wins and the completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_chan | input | CHAN_W | Channel number the command addresses |
| cmd_op | input | 3 | Operation code (1 start, 2 clear, 3 skip if done clear, 4 skip if done set, 5 mask write) |
| cmd_arg | input | 1 | Mask value for the mask-write command |
| int_enable | input | 1 | Global interrupt enable |
| op_complete | input | 1 | Completion pulse from the device datapath |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |
| skip | output | 1 | Skip response to a skip-test command |

## Verification
The bench goes after six corner cases:
- A start issued while done is already set. A design that kept done would leave the request standing after a new operation begins.
- A completion pulse that arrives while the device is idle. A design that accepted it would raise a spurious interrupt.
- A start or clear in the same cycle as a completion. A design with the wrong priority would end up with done set or busy cleared.
- Commands for a neighbouring channel, and commands with `cmd_valid` low. A design that ignored the channel would clear, start or skip for another device.
- The mask bit and the global enable, each toggled on its own while done stays set. A design with wrong gating would leave irq standing.
- The two skip tests, issued in both done states. A design with swapped polarity would skip in the wrong state.

// File: rtl/io_flag_ctrl.sv
module io_flag_ctrl #(
  parameter int CHAN_W = 6,
  parameter logic [CHAN_W-1:0] CHANNEL = CHAN_W'(12)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_arg,
  input  logic              int_enable,
  input  logic              op_complete,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              skip
);

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_CLEAR = 3'd2;
  localparam logic [2:0] OP_SKPZ  = 3'd3;
  localparam logic [2:0] OP_SKPN  = 3'd4;
  localparam logic [2:0] OP_MASK  = 3'd5;

  logic hit, do_start, do_clear, do_mask, finish, mask;

  assign hit      = cmd_valid && (cmd_chan == CHANNEL);
  assign do_start = hit && (cmd_op == OP_START);
  assign do_clear = hit && (cmd_op == OP_CLEAR);
  assign do_mask  = hit && (cmd_op == OP_MASK);
  assign finish   = op_complete && busy && !do_start && !do_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (do_clear) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (do_start) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= 1'b0;
    else if (do_mask) mask <= cmd_arg;
  end

  assign irq  = done && int_enable && !mask;
  assign skip = hit && ((cmd_op == OP_SKPZ && !done) || (cmd_op == OP_SKPN && done));

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_chan == CHANNEL && cmd_op == OP_START) |=> (busy && !done));

  a_r3_complete_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (op_complete && busy && !(cmd_valid && cmd_chan == CHANNEL &&
      (cmd_op == OP_START || cmd_op == OP_CLEAR))) |=> (!busy && done));

  a_r4_idle_complete_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (op_complete && !busy && !(cmd_valid && cmd_chan == CHANNEL &&
      (cmd_op == OP_START || cmd_op == OP_CLEAR))) |=> (!busy && $stable(done)));

  a_r6_clear_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_chan == CHANNEL && cmd_op == OP_CLEAR) |=> (!busy && !done && !irq));

  a_r8_foreign_channel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_chan != CHANNEL && !op_complete) |=> ($stable(busy) && $stable(done) && $stable(mask)));

  a_r7_foreign_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_chan != CHANNEL) |-> !skip);

endmodule

// File: tb/test_io_flag_ctrl.sv
module test_io_flag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CH = 6'd12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_arg = 1'b0, int_enable = 1'b0, op_complete = 1'b0;
  logic [5:0] cmd_chan = 6'd0;
  logic [2:0] cmd_op = 3'd0;
  logic busy, done, irq, skip;

  io_flag_ctrl #(.CHAN_W(6), .CHANNEL(CH)) i_io_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .int_enable(int_enable),
    .op_complete(op_complete), .busy(busy), .done(done), .irq(irq), .skip(skip));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string tag;
    logic  e_skip, e_busy, e_done, e_irq;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  logic m_busy = 0, m_done = 0, m_mask = 0;
  bit finished = 0;

  task automatic drive(input string tag, input logic v, input logic [5:0] ch,
                       input logic [2:0] op, input logic arg, input logic ie, input logic cpl);
    item_t it;
    logic hit;
    @(negedge clk);
    cmd_valid = v; cmd_chan = ch; cmd_op = op; cmd_arg = arg;
    int_enable = ie; op_complete = cpl;
    hit = v && (ch == CH);
    it.tag = tag;
    it.e_skip = hit && ((op == 3'd3 && !m_done) || (op == 3'd4 && m_done));
    if (hit && op == 3'd2) begin m_busy = 0; m_done = 0; end
    else if (hit && op == 3'd1) begin m_busy = 1; m_done = 0; end
    else if (cpl && m_busy) begin m_busy = 0; m_done = 1; end
    if (hit && op == 3'd5) m_mask = arg;
    it.e_busy = m_busy; it.e_done = m_done;
    it.e_irq = m_done && ie && !m_mask;
    q.push_back(it);
  endtask

  initial begin : monitor
    logic s_pre;
    item_t it;
    forever begin
      @(negedge clk); #2;
      s_pre = skip;
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (s_pre !== it.e_skip || busy !== it.e_busy || done !== it.e_done || irq !== it.e_irq) begin
          fails++;
          $display("FAIL %s: skip/busy/done/irq actual %b%b%b%b expected %b%b%b%b", it.tag,
                   s_pre, busy, done, irq, it.e_skip, it.e_busy, it.e_done, it.e_irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #3;
    checks++;
    if ({busy, done, irq, skip} !== 4'b0000) begin
      fails++;
      $display("FAIL R1 reset: actual %b%b%b%b expected 0000", busy, done, irq, skip);
    end
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    drive("R1 idle after reset", 0, CH, 3'd0, 0, 1, 0);
    drive("R2 start", 1, CH, 3'd1, 0, 1, 0);
    drive("R7 skip-if-clear while busy", 1, CH, 3'd3, 0, 1, 0);
    drive("R7 skip-if-set while busy", 1, CH, 3'd4, 0, 1, 0);
    drive("R3 R5 completion raises irq", 0, CH, 3'd0, 0, 1, 1);
    drive("R7 skip-if-set with done", 1, CH, 3'd4, 0, 1, 0);
    drive("R7 skip-if-clear with done", 1, CH, 3'd3, 0, 1, 0);
    drive("R9 R5 mask write 1", 1, CH, 3'd5, 1, 1, 0);
    drive("R9 op 6 ignored", 1, CH, 3'd6, 0, 1, 0);
    drive("R9 mask write 0", 1, CH, 3'd5, 0, 1, 0);
    drive("R5 enable low", 0, CH, 3'd0, 0, 0, 0);
    drive("R5 enable high", 0, CH, 3'd0, 0, 1, 0);
    drive("R8 foreign clear", 1, CH + 6'd1, 3'd2, 0, 1, 0);
    drive("R8 foreign skip", 1, 6'd13, 3'd4, 0, 1, 0);
    drive("R8 foreign mask", 1, 6'd0, 3'd5, 1, 1, 0);
    drive("R8 invalid clear", 0, CH, 3'd2, 0, 1, 0);
    drive("R2 start clears done", 1, CH, 3'd1, 0, 1, 0);
    drive("R3 complete", 0, CH, 3'd0, 0, 1, 1);
    drive("R6 clear", 1, CH, 3'd2, 0, 1, 0);
    drive("R4 idle completion ignored", 0, CH, 3'd0, 0, 1, 1);
    drive("R8 invalid start ignored", 0, CH, 3'd1, 0, 1, 0);
    drive("R2 start again", 1, CH, 3'd1, 0, 1, 0);
    drive("R10 start wins over completion", 1, CH, 3'd1, 0, 1, 1);
    drive("R10 clear wins over completion", 1, CH, 3'd2, 0, 1, 1);
    drive("R7 skip-if-clear after clear", 1, CH, 3'd3, 0, 1, 0);
    drive("R6 idle", 0, CH, 3'd0, 0, 1, 0);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule